// File: doc/BRIEF.md
# Signed Radix-4 Booth Multiplier

This block is a purely combinational two's-complement multiplier. A signed multiplicand of `XW` bits and a signed multiplier of `YW` bits produce a signed product of `ZW` bits within the same cycle. There is no clock, no register and no handshake, so the product follows the operands after the settling delay of the logic. The surrounding pipeline decides where to put flops.

The multiplier is scanned in overlapping three-bit groups. Each group drives one radix-4 encoder. An encoder gives an active-low select for one times the multiplicand, an active-low select for two times it, a negate flag and a correction bit.

Each encoder drives one row of `XW+1` decoders. Every decoder forms the inverted-operand term of its own multiplicand bit. It then combines that term with the term chained in from its right-hand neighbour to form one partial-product bit. The leftmost decoder of a row repeats the multiplicand's sign bit, so the row already carries its own sign.

The rows are aligned two columns apart and reduced by a carry-save array of full adders. The correction bits fill in the +1 of each negated row. A final carry-propagate addition then gives the product.

Top module: `booth_mul_signed`

## Requirements
- R1: With `ZW = XW+YW`, `product` equals the signed product of `a` and `b` for every operand pair.
- R2: When both operands hold their most negative value, the product is the positive value 2^(XW+YW-2), with its top bit clear.
- R3: When either operand is zero, every bit of `product` is zero.
- R4: With `ZW < XW+YW`, `product` holds the low `ZW` bits of the full signed product.
- R5: With `ZW > XW+YW`, `product` holds the full signed product, sign-extended to `ZW` bits.
- R6: An odd multiplier width is handled as a signed value. The multiplier's sign bit is extended into the last group, so for example a 5-bit by 3-bit instance is exact for all operand pairs.
- R7: The two lowest product bits follow the plain, non-Booth rule: bit 0 is `a[0] & b[0]`, and bit 1 is `(a[1] & b[0]) ^ (a[0] & b[1])`.
- R8: Multiplying by +1, -1, +2 and -2 gives a, -a, 2a and -2a. These four cases cover every nonzero encoder code. Within any encoder, at most one of the two active-low selects is low, and the negate flag is set only when a select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | XW | Signed multiplicand |
| b | input | YW | Signed multiplier, scanned by the encoders |
| product | output | ZW | Signed product, truncated or sign-extended to ZW bits |

## Verification
The block holds no state. A wrong encoder code or a broken link in a row's inverted-operand chain therefore shows at `product` in the same evaluation, as a wrong value. The error is always a multiple of a power of four tied to that row. A dropped correction bit gives an error of exactly one unit at the row's column. The bench therefore sweeps every pair at small widths, including odd ones, so that every encoder code meets every multiplicand pattern. At full width it adds corner values and the four single-code multipliers.

// File: rtl/booth_pkg.sv
package booth_pkg;

    // Output of one radix-4 encoder: selects are active low
    typedef struct packed {
        logic neg;     // selected multiple is negated
        logic two_n;   // low: pick two times the multiplicand
        logic one_n;   // low: pick one times the multiplicand
        logic cor;     // +1 that completes the negation of the row
    } sel_t;

    // Group value is -2*hi + mid + lo
    function automatic sel_t encode(input logic hi, input logic mid, input logic lo);
        sel_t s;
        logic one, two;
        one     = mid ^ lo;
        two     = (hi & ~mid & ~lo) | (~hi & mid & lo);
        s.neg   = hi & ~(mid & lo);
        s.two_n = ~two;
        s.one_n = ~one;
        s.cor   = hi & ~(mid & lo);
        return s;
    endfunction

    function automatic int unsigned group_count(input int unsigned width);
        return (width + 1) / 2;
    endfunction

endpackage

// File: rtl/booth_enc_bank.sv
module booth_enc_bank
    import booth_pkg::*;
#(
    parameter int unsigned YW  = 16,
    parameter int unsigned ENC = group_count(YW)
) (
    input  logic [YW-1:0] b,
    output sel_t          sel [ENC]
);
    localparam int unsigned BXW = 2 * ENC + 1;

    // Multiplier with an implied zero below bit 0 and its sign extended on top
    logic [BXW-1:0] bx;

    genvar k;
    generate
        for (k = 0; k < BXW; k++) begin : g_ext
            if (k == 0) begin : g_zero
                assign bx[k] = 1'b0;
            end else if (k - 1 < YW) begin : g_bit
                assign bx[k] = b[k-1];
            end else begin : g_sign
                assign bx[k] = b[YW-1];
            end
        end

        for (k = 0; k < ENC; k++) begin : g_enc
            assign sel[k] = encode(bx[2*k+2], bx[2*k+1], bx[2*k]);

            always_comb begin
                // R8: the two selects never act together
                p_sel_exclusive_r8: assert (sel[k].two_n | sel[k].one_n);
                // R8: negation only comes with a nonzero multiple
                p_neg_needs_sel_r8: assert (!sel[k].neg || !(sel[k].two_n && sel[k].one_n));
            end
        end
    endgenerate

endmodule

// File: rtl/booth_row.sv
module booth_row
    import booth_pkg::*;
#(
    parameter int unsigned XW = 16
) (
    input  logic [XW-1:0] a,
    input  sel_t          sel,
    output logic [XW:0]   pp
);
    // Multiplicand with its sign bit repeated for the extra decoder
    logic [XW:0] xe;
    // Inverted-operand term of each decoder
    logic [XW:0] nx;

    assign xe = {a[XW-1], a};

    genvar j;
    generate
        for (j = 0; j <= XW; j++) begin : g_dec
            logic nx_right;
            assign nx[j] = ~(xe[j] ^ sel.neg);
            if (j == 0) begin : g_first
                // The bit to the right of bit 0 is zero
                assign nx_right = ~sel.neg;
            end else begin : g_chain
                assign nx_right = nx[j-1];
            end
            assign pp[j] = ~((nx_right | sel.two_n) & (nx[j] | sel.one_n));
        end
    endgenerate

    always_comb begin
        // R3: a row with no multiple selected contributes nothing
        p_idle_row_zero_r3: assert (!(sel.two_n && sel.one_n) || (pp == '0));
    end

endmodule

// File: rtl/booth_reduce.sv
module booth_reduce #(
    parameter int unsigned ENC = 8,
    parameter int unsigned RW  = 17,
    parameter int unsigned PW  = 32
) (
    input  logic [ENC-1:0][RW-1:0] rows,
    input  logic [ENC-1:0]         cor,
    output logic [PW-1:0]          sum
);
    localparam int unsigned EXT = PW - RW;

    logic [PW-1:0] aligned [ENC];
    logic [PW-1:0] corv;
    logic [PW-1:0] s_st [ENC];
    logic [PW-1:0] c_st [ENC];

    genvar i;
    generate
        for (i = 0; i < ENC; i++) begin : g_align
            logic [PW-1:0] ext;
            assign ext        = {{EXT{rows[i][RW-1]}}, rows[i]};
            assign aligned[i] = ext << (2 * i);
        end
    endgenerate

    // Correction bits sit at the first column of their rows
    always_comb begin
        corv = '0;
        for (int n = 0; n < ENC; n++) begin
            corv[2*n] = cor[n];
        end
    end

    assign s_st[0] = aligned[0];
    assign c_st[0] = corv;

    // Full-adder array: one carry-save row per partial product
    generate
        for (i = 1; i < ENC; i++) begin : g_csa
            assign s_st[i] = s_st[i-1] ^ c_st[i-1] ^ aligned[i];
            assign c_st[i] = ((s_st[i-1] & c_st[i-1]) |
                              (s_st[i-1] & aligned[i]) |
                              (c_st[i-1] & aligned[i])) << 1;
        end
    endgenerate

    assign sum = s_st[ENC-1] + c_st[ENC-1];

endmodule

// File: rtl/booth_mul_signed.sv
module booth_mul_signed
    import booth_pkg::*;
#(
    parameter int unsigned XW = 16,
    parameter int unsigned YW = 16,
    parameter int unsigned ZW = XW + YW
) (
    input  logic [XW-1:0] a,
    input  logic [YW-1:0] b,
    output logic [ZW-1:0] product
);
    localparam int unsigned ENC = group_count(YW);
    localparam int unsigned RW  = XW + 1;
    localparam int unsigned PW  = XW + YW;

    sel_t                  sel [ENC];
    logic [ENC-1:0][RW-1:0] rows;
    logic [ENC-1:0]         cors;
    logic [PW-1:0]          full;

    booth_enc_bank #(.YW(YW), .ENC(ENC)) u_enc (
        .b   (b),
        .sel (sel)
    );

    genvar g;
    generate
        for (g = 0; g < ENC; g++) begin : g_rows
            booth_row #(.XW(XW)) u_row (
                .a   (a),
                .sel (sel[g]),
                .pp  (rows[g])
            );
            assign cors[g] = sel[g].cor;
        end
    endgenerate

    booth_reduce #(.ENC(ENC), .RW(RW), .PW(PW)) u_red (
        .rows (rows),
        .cor  (cors),
        .sum  (full)
    );

    generate
        if (ZW > PW) begin : g_wide
            assign product = {{(ZW-PW){full[PW-1]}}, full};
        end else begin : g_fit
            assign product = full[ZW-1:0];
        end
    endgenerate

    always_comb begin
        // R7: low two bits match the plain AND/XOR rule
        p_low_bits_r7: assert (full[0] == (a[0] & b[0]) &&
                               full[1] == ((a[1] & b[0]) ^ (a[0] & b[1])));
        // R3: a zero operand yields zero
        p_zero_operand_r3: assert (!((a == '0) || (b == '0)) || (full == '0));
        // R2: the most negative squared is positive
        p_min_times_min_r2: assert (!(a == {1'b1, {(XW-1){1'b0}}} &&
                                      b == {1'b1, {(YW-1){1'b0}}}) || !full[PW-1]);
    end

endmodule

// File: tb/booth_mul_signed_test.sv
module booth_mul_signed_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // 16x16 main instance
    logic [15:0] a16, b16;
    logic [31:0] p16;
    booth_mul_signed #(.XW(16), .YW(16), .ZW(32)) uut (.a(a16), .b(b16), .product(p16));

    logic [3:0] a4, b4;
    logic [7:0] p4;
    booth_mul_signed #(.XW(4), .YW(4), .ZW(8)) uut4 (.a(a4), .b(b4), .product(p4));

    logic [5:0] a6, b6;
    logic [11:0] p6;
    booth_mul_signed #(.XW(6), .YW(6), .ZW(12)) uut6 (.a(a6), .b(b6), .product(p6));

    logic [4:0] ao;
    logic [2:0] bo;
    logic [7:0] po;
    booth_mul_signed #(.XW(5), .YW(3), .ZW(8)) uut_odd (.a(ao), .b(bo), .product(po));

    logic [5:0] an, bn;
    logic [7:0] pn;
    booth_mul_signed #(.XW(6), .YW(6), .ZW(8)) uut_narrow (.a(an), .b(bn), .product(pn));

    logic [3:0] aw, bw;
    logic [11:0] pw;
    booth_mul_signed #(.XW(4), .YW(4), .ZW(12)) uut_wide (.a(aw), .b(bw), .product(pw));

    task automatic check(input string req, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic settle;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset_state;
        a16 = '0; b16 = '0; a4 = '0; b4 = '0; a6 = '0; b6 = '0;
        ao = '0; bo = '0; an = '0; bn = '0; aw = '0; bw = '0;
        settle();
        check("R3 all-zero start", longint'(p16), 0);
    endtask

    task automatic t_exhaustive_small;
        for (int x = -8; x < 8; x++) begin
            for (int y = -8; y < 8; y++) begin
                a4 = 4'(x); b4 = 4'(y);
                aw = 4'(x); bw = 4'(y);
                settle();
                check("R1 4x4", longint'($signed(p4)), longint'(x * y));
                check("R5 4x4 into 12", longint'($signed(pw)), longint'(x * y));
            end
        end
        for (int x = -32; x < 32; x++) begin
            for (int y = -32; y < 32; y++) begin
                a6 = 6'(x); b6 = 6'(y);
                an = 6'(x); bn = 6'(y);
                settle();
                check("R1 6x6", longint'($signed(p6)), longint'(x * y));
                check("R4 6x6 into 8", longint'(pn), longint'((x * y) & 255));
            end
        end
    endtask

    task automatic t_odd_width;
        for (int x = -16; x < 16; x++) begin
            for (int y = -4; y < 4; y++) begin
                ao = 5'(x); bo = 3'(y);
                settle();
                check("R6 5x3", longint'($signed(po)), longint'(x * y));
            end
        end
    endtask

    task automatic one16(input string req, input int x, input int y);
        a16 = 16'(x); b16 = 16'(y);
        settle();
        check(req, longint'($signed(p16)), longint'(x) * longint'(y));
    endtask

    task automatic t_corners16;
        int vals [6] = '{0, -1, 1, -32768, 32767, -2};
        foreach (vals[i]) begin
            foreach (vals[j]) begin
                one16("R1 16x16 corner", vals[i], vals[j]);
            end
        end
        one16("R2 min*min", -32768, -32768);
        check("R2 top bit clear", longint'(p16[31]), 0);
        one16("R3 zero b", 12345, 0);
        one16("R3 zero a", 0, -777);
    endtask

    task automatic t_codes16;
        int mults [4] = '{1, -1, 2, -2};
        int as_ [5] = '{-32768, 32767, 21845, -4660, 1};
        foreach (mults[m]) begin
            foreach (as_[i]) begin
                one16("R8 single code", as_[i], mults[m]);
            end
        end
    endtask

    task automatic t_random16;
        for (int n = 0; n < 3000; n++) begin
            int x, y;
            x = $signed(16'($urandom));
            y = $signed(16'($urandom));
            one16("R1 16x16 random", x, y);
            check("R7 bit0", longint'(p16[0]), longint'(a16[0] & b16[0]));
            check("R7 bit1", longint'(p16[1]),
                  longint'((a16[1] & b16[0]) ^ (a16[0] & b16[1])));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        rst = 1'b0;
        t_reset_state();
        t_exhaustive_small();
        t_odd_width();
        t_corners16();
        t_codes16();
        t_random16();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule